// File: doc/BRIEF.md
# Two-Line Level Interrupt Aggregator

The block gathers 32 level-sensitive interrupt sources into two processor interrupt lines. Each source passes through a clock-domain synchronizer. It is then qualified by a per-source enable mask and steered by a per-source route bit to line 0 or line 1. The topmost mask bit also acts as a master switch: while it is clear, neither line can assert, whatever the sources or routes.

Software reaches the block through a single-cycle register port. Read data is returned combinationally in the same cycle as the address. Writes take effect on the clock edge where the write strobe is high. The mask cannot be written directly. Software sets mask bits through an arm register and clears them through a disarm register. Each takes a bit vector where a 1 acts on that position and a 0 leaves it alone, so no read-modify-write sequence is needed.

Register offsets (byte addresses): 0x00 line-0 status, 0x04 line-1 status, 0x20 route, 0x30 level (synchronized raw inputs), 0x34 arm (reads back the mask), 0x38 disarm.

Top module: `irq_hub`

## Requirements
- R1: After reset the mask (including bit 31) and the route register are zero, both interrupt lines are low, and every register reads zero while all sources are low.
- R2: A write to offset 0x34 sets each mask bit written as 1 and keeps each bit written as 0. A read of 0x34 returns the current mask.
- R3: A write to offset 0x38 clears each mask bit written as 1 and keeps the others. A read of 0x38 returns zero.
- R4: While mask bit 31 is 0, both interrupt lines stay low.
- R5: Offset 0x00 reads level & mask & ~route. Line 0 is high exactly when that value is nonzero and mask bit 31 is 1.
- R6: Offset 0x04 reads level & mask & route. Line 1 is high exactly when that value is nonzero and mask bit 31 is 1. A route bit of 1 selects line 1 and a route bit of 0 selects line 0. Offset 0x20 is read/write and holds the route bits.
- R7: Offset 0x30 returns the synchronized source levels, whatever the mask, route or bit 31 hold.
- R8: A source change made before a clock edge appears in the level register after the second edge and not after the first.
- R9: Writes to offsets 0x00, 0x04 and 0x30 change no state. A read of any offset not listed above returns zero.
- R10: The two status registers are not gated by mask bit 31. They report qualified sources even while the lines are held low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 32 | Level-sensitive interrupt sources, asynchronous |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, acts on the rising clock edge |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| irq0_o | output | 1 | Interrupt line 0 |
| irq1_o | output | 1 | Interrupt line 1 |

## Verification
The hardest state to reach is one where the status registers are nonzero while the lines are low. That takes armed sources that are pending while bit 31 is clear. The stimulus arms the low mask bits first and checks both status and lines, then sets bit 31. Later it clears bit 31 alone through the disarm register while the sources stay asserted. The synchronizer lag is probed by reading the level register one edge after a source change, and again after the second edge.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

    localparam logic [15:0] OFS_STAT0  = 16'h0000;
    localparam logic [15:0] OFS_STAT1  = 16'h0004;
    localparam logic [15:0] OFS_ROUTE  = 16'h0020;
    localparam logic [15:0] OFS_LEVEL  = 16'h0030;
    localparam logic [15:0] OFS_ARM    = 16'h0034;
    localparam logic [15:0] OFS_DISARM = 16'h0038;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STAT0,
        SEL_STAT1,
        SEL_ROUTE,
        SEL_LEVEL,
        SEL_ARM,
        SEL_DISARM
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [15:0] addr);
        reg_sel_e sel;
        case (addr)
            OFS_STAT0:  sel = SEL_STAT0;
            OFS_STAT1:  sel = SEL_STAT1;
            OFS_ROUTE:  sel = SEL_ROUTE;
            OFS_LEVEL:  sel = SEL_LEVEL;
            OFS_ARM:    sel = SEL_ARM;
            OFS_DISARM: sel = SEL_DISARM;
            default:    sel = SEL_NONE;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/irq_hub_sync.sv
module irq_hub_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.chain[STAGES-1];

endmodule

// File: rtl/irq_hub_regs.sv
module irq_hub_regs #(
    parameter int NSRC   = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NSRC-1:0]   bus_wdata,
    input  logic              bus_we,
    output logic [NSRC-1:0]   mask_o,
    output logic [NSRC-1:0]   route_o
);
    import irq_hub_pkg::*;

    typedef struct packed {
        logic [NSRC-1:0] mask;
        logic [NSRC-1:0] route;
    } cfg_state_t;

    cfg_state_t st_d, st_q;
    reg_sel_e   wsel;

    assign wsel = decode_addr(16'(bus_addr));

    always_comb begin
        st_d = st_q;
        if (bus_we) begin
            case (wsel)
                SEL_ARM:    st_d.mask  = st_q.mask | bus_wdata;
                SEL_DISARM: st_d.mask  = st_q.mask & ~bus_wdata;
                SEL_ROUTE:  st_d.route = bus_wdata;
                default:    st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o  = st_q.mask;
    assign route_o = st_q.route;

    AST_ARM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bus_we) && $past(wsel) == SEL_ARM)
        |-> ((mask_o & $past(bus_wdata)) == $past(bus_wdata))
            && ((mask_o & ~$past(bus_wdata)) == ($past(mask_o) & ~$past(bus_wdata)))); // R2

    AST_DISARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bus_we) && $past(wsel) == SEL_DISARM)
        |-> ((mask_o & $past(bus_wdata)) == '0)
            && ((mask_o & ~$past(bus_wdata)) == ($past(mask_o) & ~$past(bus_wdata)))); // R3

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !($past(bus_we) && ($past(wsel) == SEL_ARM || $past(wsel) == SEL_DISARM)))
        |-> $stable(mask_o)); // R9

    AST_ROUTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !($past(bus_we) && $past(wsel) == SEL_ROUTE))
        |-> $stable(route_o)); // R9

endmodule

// File: rtl/irq_hub_steer.sv
module irq_hub_steer #(
    parameter int NSRC = 32
) (
    input  logic [NSRC-1:0] level_i,
    input  logic [NSRC-1:0] mask_i,
    input  logic [NSRC-1:0] route_i,
    output logic [NSRC-1:0] stat0_o,
    output logic [NSRC-1:0] stat1_o,
    output logic            irq0_o,
    output logic            irq1_o
);
    localparam int GBIT = NSRC - 1;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        logic qual;
        assign qual       = level_i[s] & mask_i[s];
        assign stat0_o[s] = qual & ~route_i[s];
        assign stat1_o[s] = qual &  route_i[s];
    end

    assign irq0_o = mask_i[GBIT] & (|stat0_o);
    assign irq1_o = mask_i[GBIT] & (|stat1_o);

endmodule

// File: rtl/irq_hub_rdmux.sv
module irq_hub_rdmux #(
    parameter int NSRC   = 32,
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NSRC-1:0]   stat0_i,
    input  logic [NSRC-1:0]   stat1_i,
    input  logic [NSRC-1:0]   route_i,
    input  logic [NSRC-1:0]   level_i,
    input  logic [NSRC-1:0]   mask_i,
    output logic [NSRC-1:0]   rdata_o
);
    import irq_hub_pkg::*;

    reg_sel_e rsel;
    assign rsel = decode_addr(16'(bus_addr));

    always_comb begin
        case (rsel)
            SEL_STAT0: rdata_o = stat0_i;
            SEL_STAT1: rdata_o = stat1_i;
            SEL_ROUTE: rdata_o = route_i;
            SEL_LEVEL: rdata_o = level_i;
            SEL_ARM:   rdata_o = mask_i;
            default:   rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/irq_hub.sv
module irq_hub #(
    parameter int NSRC        = 32,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NSRC-1:0]   bus_wdata,
    input  logic              bus_we,
    output logic [NSRC-1:0]   bus_rdata,
    output logic              irq0_o,
    output logic              irq1_o
);
    localparam int GBIT = NSRC - 1;

    logic [NSRC-1:0] level, mask, route, stat0, stat1;

    irq_hub_sync #(.WIDTH(NSRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (src_i),
        .level_o (level)
    );

    irq_hub_regs #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .mask_o    (mask),
        .route_o   (route)
    );

    irq_hub_steer #(.NSRC(NSRC)) u_steer (
        .level_i (level),
        .mask_i  (mask),
        .route_i (route),
        .stat0_o (stat0),
        .stat1_o (stat1),
        .irq0_o  (irq0_o),
        .irq1_o  (irq1_o)
    );

    irq_hub_rdmux #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_rdmux (
        .bus_addr (bus_addr),
        .stat0_i  (stat0),
        .stat1_i  (stat1),
        .route_i  (route),
        .level_i  (level),
        .mask_i   (mask),
        .rdata_o  (bus_rdata)
    );

    AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !mask[GBIT] |-> (!irq0_o && !irq1_o)); // R4

    AST_LINES_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        (stat0 & stat1) == '0); // R6

    AST_STAT_WITHIN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat0 | stat1) & ~(level & mask)) == '0); // R5

    AST_RESET_CLEAN: assert property (@(posedge clk)
        $rose(rst_n) |-> (mask == '0 && route == '0 && !irq0_o && !irq1_o)); // R1

endmodule

// File: tb/irq_hub_test.sv
module irq_hub_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_i = '0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq0_o, irq1_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_hub uut (
        .clk(clk), .rst_n(rst_n), .src_i(src_i),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .bus_rdata(bus_rdata), .irq0_o(irq0_o), .irq1_o(irq1_o)
    );

    typedef struct {
        logic [31:0] rdata;
        logic        irq0;
        logic        irq1;
        string       tag;
    } exp_t;

    exp_t expq[$];
    event sample_ev;

    // reference model state
    logic [31:0] m_mask = '0, m_route = '0, m_level = '0;

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h00: return m_level & m_mask & ~m_route;
            8'h04: return m_level & m_mask & m_route;
            8'h20: return m_route;
            8'h30: return m_level;
            8'h34: return m_mask;
            default: return 32'h0;
        endcase
    endfunction

    // driver: pushes expectation, then triggers the monitor
    task automatic probe(input logic [7:0] a, input string tag);
        exp_t e;
        e.rdata = m_read(a);
        e.irq0  = m_mask[31] && ((m_level & m_mask & ~m_route) != 0);
        e.irq1  = m_mask[31] && ((m_level & m_mask &  m_route) != 0);
        e.tag   = tag;
        bus_addr = a;
        expq.push_back(e);
        -> sample_ev;
        #2;
    endtask

    task automatic probe_raw(input logic [31:0] exp_level, input string tag);
        exp_t e;
        e.rdata = exp_level;
        e.irq0  = irq0_o;
        e.irq1  = irq1_o;
        e.tag   = tag;
        bus_addr = 8'h30;
        expq.push_back(e);
        -> sample_ev;
        #2;
    endtask

    // monitor: pops and compares
    initial begin
        forever begin
            @(sample_ev);
            #1;
            while (expq.size() > 0) begin
                exp_t e;
                e = expq.pop_front();
                checks++;
                if (bus_rdata !== e.rdata) begin
                    errors++;
                    $display("FAIL %s addr=%h rdata actual=%h expected=%h", e.tag, bus_addr, bus_rdata, e.rdata);
                end
                checks++;
                if (irq0_o !== e.irq0 || irq1_o !== e.irq1) begin
                    errors++;
                    $display("FAIL %s lines actual=%b%b expected=%b%b", e.tag, irq1_o, irq0_o, e.irq1, e.irq0);
                end
            end
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        case (a)
            8'h34: m_mask = m_mask | d;
            8'h38: m_mask = m_mask & ~d;
            8'h20: m_route = d;
            default: ;
        endcase
    endtask

    task automatic set_src(input logic [31:0] v);
        @(negedge clk);
        src_i = v;
        @(negedge clk);
        @(negedge clk);
        m_level = v;
    endtask

    task automatic all_regs(input string tag);
        probe(8'h00, tag); probe(8'h04, tag); probe(8'h20, tag);
        probe(8'h30, tag); probe(8'h34, tag); probe(8'h38, tag);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        all_regs("R1 reset");

        set_src(32'h8000_A5C3);
        probe(8'h30, "R7 level unmasked");
        probe(8'h00, "R5 stat0 no mask");

        // synchronizer lag
        @(negedge clk);
        src_i = 32'h0F00_00FF;
        @(negedge clk);
        probe_raw(32'h8000_A5C3, "R8 one edge old");
        @(negedge clk);
        m_level = 32'h0F00_00FF;
        probe(8'h30, "R8 two edges new");

        bus_write(8'h34, 32'h0000_00FF);
        probe(8'h34, "R2 arm readback");
        probe(8'h00, "R10 stat0 without global");
        probe(8'h00, "R4 lines low without global");

        bus_write(8'h34, 32'h8000_0000);
        probe(8'h34, "R2 arm keeps others");
        probe(8'h00, "R5 line0 asserted");

        bus_write(8'h20, 32'h0000_000F);
        probe(8'h20, "R6 route readback");
        probe(8'h04, "R6 stat1 routed");
        probe(8'h00, "R5 stat0 remainder");

        bus_write(8'h20, 32'hFFFF_FFFF);
        probe(8'h00, "R6 all to line1 stat0");
        probe(8'h04, "R6 all to line1 stat1");

        bus_write(8'h38, 32'h0000_0003);
        probe(8'h34, "R3 disarm clears");
        probe(8'h38, "R3 disarm reads zero");

        bus_write(8'h00, 32'hFFFF_FFFF);
        bus_write(8'h04, 32'hFFFF_FFFF);
        bus_write(8'h30, 32'h0000_0000);
        all_regs("R9 status writes ignored");
        probe(8'h10, "R9 unmapped reads zero");
        probe(8'h3C, "R9 unmapped reads zero");

        bus_write(8'h20, 32'h0000_0000);
        bus_write(8'h38, 32'h8000_0000);
        probe(8'h34, "R3 global cleared");
        probe(8'h00, "R4 R10 stat kept lines low");

        bus_write(8'h34, 32'hFFFF_FFFF);
        set_src(32'h0000_0000);
        all_regs("R7 sources idle");
        set_src(32'h8000_0000);
        probe(8'h00, "R5 source 31 on line0");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule